// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table that sits in memory. A client hands over one request at a time: the virtual address and whether the access is a write. The walker reads the first-level entry from a table whose base address comes in on a separate input. If that entry is present, it reads the second-level entry through the same single-outstanding memory read port. It then answers with the physical address and the page's flag bits, or with a failure code.

There are two kinds of failure. A page fault covers a missing entry at either level, and also an access the page does not allow. A bus error means a memory read came back with its error flag set. On any failure the faulting virtual address and the write flag are kept on dedicated outputs, so that a register block can show them. Address bits 31:22 select one of 1024 first-level words, bits 21:12 select one of 1024 second-level words, and bits 11:0 pass through unchanged as the page offset.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk uses address `dirBase + 4*va[31:22]`.
- R2: When the first-level entry is present, the second read uses address `{l1[31:12], 12'h000} + 4*va[21:12]`.
- R3: If bit 0 (present) of the first-level entry is 0, the walk ends with status 1 (page fault) after exactly one memory read.
- R4: If bit 0 of the second-level entry is 0, the walk ends with status 1 (page fault) after two memory reads.
- R5: A successful walk returns status 0, `rspPaddr = {l2[31:12], va[11:0]}` and `rspFlags = l2[8:1]`. In that field, bit 0 is read permission, bit 1 is write permission, and bits 7:2 are the cache attributes.
- R6: A write request to a page whose entry bit 2 is 0, or a read request to a page whose entry bit 1 is 0, ends with status 1 (page fault).
- R7: A read answered with `memRdErr` high ends the walk at once with status 2 (bus error), at either level.
- R8: On status 1 or 2, `faultAddr` takes the request's virtual address and `faultWrite` takes its write flag, while `rspPaddr` and `rspFlags` read zero.
- R9: `reqReady` falls after a request is accepted and stays low until the response handshake completes. `rspValid` stays high until `rspReady` is seen.
- R10: After reset, `reqReady` is 1, `rspValid` is 0, `memRdValid` is 0 and `faultAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirBase | input | 32 | Byte address of the first-level table |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Request is a write access |
| rspValid | output | 1 | Result valid |
| rspReady | input | 1 | Client accepts the result |
| rspPaddr | output | 32 | Translated physical address, zero on failure |
| rspFlags | output | 8 | Page entry bits 8:1, zero on failure |
| rspStatus | output | 2 | 0 ok, 1 page fault, 2 bus error |
| faultAddr | output | 32 | Virtual address of the last failed walk |
| faultWrite | output | 1 | Write flag of the last failed walk |
| memRdValid | output | 1 | Memory read request valid |
| memRdReady | input | 1 | Memory accepts the read address |
| memRdAddr | output | 32 | Byte address of the entry read |
| memRdDataValid | input | 1 | Read data returned |
| memRdData | input | 32 | Returned entry |
| memRdErr | input | 1 | Returned read failed |

## Verification
Walks are run against a sparse memory model with these table layouts: fully present pages with attributes set, a missing first-level entry, and a missing second-level entry. Each case shows whether the second read is skipped or issued. Read-only and write-only pages are probed with both access types, which separates the permission check from the present check. Errors are injected on the first read and on the second read, which separates a bus error from a page fault and from an early or late abort. A second table base tests that the first-level address really follows `dirBase`. One response is also held back for a few cycles, to show that the result stays steady and that no new request is accepted during that time.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_PAGE = 2'd1,
    ST_BUS  = 2'd2
  } walkStatus_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_L1REQ,
    S_L1WAIT,
    S_L2REQ,
    S_L2WAIT,
    S_RESP
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        capReq;
    logic        capL1;
    logic        capL2;
    logic        setResult;
    walkStatus_e result;
  } walkStrobe_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        rspValid,
  input  logic        rspReady,
  output logic        memRdValid,
  input  logic        memRdReady,
  input  logic        memRdDataValid,
  input  logic        memRdErr,
  input  logic        entryPresent,
  input  logic        permOk,
  output logic        memSel,
  output walkStrobe_t strb
);

  walkState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      S_IDLE: if (reqValid) begin
        strb.capReq = 1'b1;
        stateNext   = S_L1REQ;
      end
      S_L1REQ: if (memRdReady) stateNext = S_L1WAIT;
      S_L1WAIT: if (memRdDataValid) begin
        if (memRdErr) begin
          strb.setResult = 1'b1;
          strb.result    = ST_BUS;
          stateNext      = S_RESP;
        end else if (!entryPresent) begin
          strb.setResult = 1'b1;
          strb.result    = ST_PAGE;
          stateNext      = S_RESP;
        end else begin
          strb.capL1 = 1'b1;
          stateNext  = S_L2REQ;
        end
      end
      S_L2REQ: if (memRdReady) stateNext = S_L2WAIT;
      S_L2WAIT: if (memRdDataValid) begin
        strb.setResult = 1'b1;
        stateNext      = S_RESP;
        if (memRdErr)                      strb.result = ST_BUS;
        else if (!entryPresent || !permOk) strb.result = ST_PAGE;
        else begin
          strb.result = ST_OK;
          strb.capL2  = 1'b1;
        end
      end
      S_RESP: if (rspReady) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign reqReady   = (state == S_IDLE);
  assign rspValid   = (state == S_RESP);
  assign memRdValid = (state == S_L1REQ) || (state == S_L2REQ);
  assign memSel     = (state == S_L2REQ);

  // R9: once a request is taken, no second one is accepted next cycle
  a_r9_single_walk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R9: the response is held until it is taken
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int FLAG_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic              memSel,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              entryPresent,
  output logic              permOk,
  output logic [ADDR_W-1:0] walkVaddr,
  output logic              walkWrite,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [FLAG_W-1:0] rspFlags,
  output logic [1:0]        rspStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultWrite
);

  localparam int IDX1_LSB = OFF_BITS + L2_BITS;
  localparam int BASE_W   = ADDR_W - OFF_BITS;

  logic [ADDR_W-1:0] vaQ;
  logic              wrQ;
  logic [BASE_W-1:0] l1BaseQ;
  logic [ADDR_W-1:0] l2Q;
  walkStatus_e       statusQ;
  logic [ADDR_W-1:0] faultAddrQ;
  logic              faultWrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ        <= '0;
      wrQ        <= 1'b0;
      l1BaseQ    <= '0;
      l2Q        <= '0;
      statusQ    <= ST_OK;
      faultAddrQ <= '0;
      faultWrQ   <= 1'b0;
    end else begin
      if (strb.capReq) begin
        vaQ <= reqVaddr;
        wrQ <= reqWrite;
      end
      if (strb.capL1) l1BaseQ <= memRdData[ADDR_W-1:OFF_BITS];
      if (strb.capL2) l2Q     <= memRdData;
      if (strb.setResult) begin
        statusQ <= strb.result;
        if (strb.result != ST_OK) begin
          faultAddrQ <= vaQ;
          faultWrQ   <= wrQ;
        end
      end
    end
  end

  logic [ADDR_W-1:0] l1Addr, l2Addr;
  assign l1Addr = dirBase + ADDR_W'({vaQ[ADDR_W-1:IDX1_LSB], 2'b00});
  assign l2Addr = {l1BaseQ, {OFF_BITS{1'b0}}} + ADDR_W'({vaQ[IDX1_LSB-1:OFF_BITS], 2'b00});
  assign memRdAddr = memSel ? l2Addr : l1Addr;

  assign entryPresent = memRdData[0];
  assign permOk       = wrQ ? memRdData[2] : memRdData[1];

  assign walkVaddr  = vaQ;
  assign walkWrite  = wrQ;
  assign rspStatus  = statusQ;
  assign rspPaddr   = (statusQ == ST_OK) ? {l2Q[ADDR_W-1:OFF_BITS], vaQ[OFF_BITS-1:0]} : '0;
  assign rspFlags   = (statusQ == ST_OK) ? l2Q[FLAG_W:1] : '0;
  assign faultAddr  = faultAddrQ;
  assign faultWrite = faultWrQ;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int FLAG_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [FLAG_W-1:0] rspFlags,
  output logic [1:0]        rspStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultWrite,
  output logic              memRdValid,
  input  logic              memRdReady,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdDataValid,
  input  logic [ADDR_W-1:0] memRdData,
  input  logic              memRdErr
);

  walkStrobe_t       strb;
  logic              memSel, entryPresent, permOk, walkWrite;
  logic [ADDR_W-1:0] walkVaddr;

  walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .memRdValid(memRdValid), .memRdReady(memRdReady),
    .memRdDataValid(memRdDataValid), .memRdErr(memRdErr),
    .entryPresent(entryPresent), .permOk(permOk),
    .memSel(memSel), .strb(strb)
  );

  walk_dpath #(
    .ADDR_W(ADDR_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
    .OFF_BITS(OFF_BITS), .FLAG_W(FLAG_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .memSel(memSel),
    .dirBase(dirBase), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .memRdData(memRdData), .memRdAddr(memRdAddr),
    .entryPresent(entryPresent), .permOk(permOk),
    .walkVaddr(walkVaddr), .walkWrite(walkWrite),
    .rspPaddr(rspPaddr), .rspFlags(rspFlags), .rspStatus(rspStatus),
    .faultAddr(faultAddr), .faultWrite(faultWrite)
  );

  // R1/R2: a pending read keeps its address until it is accepted
  a_r2_rd_stable: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && !memRdReady |=> memRdValid && $stable(memRdAddr));

  // R6: a granted write carries the write permission flag
  a_r6_write_perm: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus == ST_OK && walkWrite |-> rspFlags[1]);

  // R6: a granted read carries the read permission flag
  a_r6_read_perm: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus == ST_OK && !walkWrite |-> rspFlags[0]);

  // R8: a failed walk exposes its own address and direction
  a_r8_fault_capture: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus != ST_OK |-> faultAddr == walkVaddr && faultWrite == walkWrite);

  // R8: a failure hides the translation
  a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus != ST_OK |-> rspPaddr == '0 && rspFlags == '0);

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dirBase = 32'h0001_0000;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspPaddr;
  logic [7:0]  rspFlags;
  logic [1:0]  rspStatus;
  logic [31:0] faultAddr;
  logic        faultWrite;
  logic        memRdValid;
  logic        memRdReady = 1'b1;
  logic [31:0] memRdAddr;
  logic        memRdDataValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        memRdErr = 1'b0;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .dirBase(dirBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr), .rspFlags(rspFlags),
    .rspStatus(rspStatus), .faultAddr(faultAddr), .faultWrite(faultWrite),
    .memRdValid(memRdValid), .memRdReady(memRdReady), .memRdAddr(memRdAddr),
    .memRdDataValid(memRdDataValid), .memRdData(memRdData), .memRdErr(memRdErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int holdCycles = 0;
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  logic [31:0] memArr [logic [31:0]];

  // scoreboard queues
  logic [1:0]  expStatQ[$];
  logic [31:0] expPaddrQ[$];
  logic [7:0]  expFlagsQ[$];
  logic [31:0] expVaQ[$];
  bit          expWrQ[$];
  string       tagQ[$];
  logic [31:0] expAddrQ[$];
  int          expNQ[$];
  logic [31:0] gotAddrQ[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return memArr.exists(a) ? memArr[a] : 32'h0;
  endfunction

  // driver: compute expectation from the table, then issue the request
  task automatic doWalk(input logic [31:0] va, input bit wr, input string tag);
    logic [31:0] a1, a2, e1, e2;
    logic [1:0]  st;
    int          n;
    a1 = dirBase + {20'h0, va[31:22], 2'b00};
    e1 = rd(a1);
    n = 1; st = 2'd0; e2 = '0;
    expAddrQ.push_back(a1);
    if (a1 == errAddr) st = 2'd2;
    else if (!e1[0]) st = 2'd1;
    else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      e2 = rd(a2);
      n = 2;
      expAddrQ.push_back(a2);
      if (a2 == errAddr) st = 2'd2;
      else if (!e2[0] || (wr ? !e2[2] : !e2[1])) st = 2'd1;
    end
    expStatQ.push_back(st);
    expPaddrQ.push_back(st == 2'd0 ? {e2[31:12], va[11:0]} : 32'h0);
    expFlagsQ.push_back(st == 2'd0 ? e2[8:1] : 8'h0);
    expVaQ.push_back(va);
    expWrQ.push_back(wr);
    expNQ.push_back(n);
    tagQ.push_back(tag);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9 reqReady low after accept", {31'h0, reqReady}, 32'h0);
    while (expStatQ.size() != 0) @(negedge clk);
  endtask

  // memory model: one read at a time, data one cycle after acceptance
  initial begin
    forever begin
      @(negedge clk);
      memRdDataValid = 1'b0;
      memRdErr = 1'b0;
      if (rstN && memRdValid) begin
        logic [31:0] a;
        a = memRdAddr;
        gotAddrQ.push_back(a);
        @(negedge clk);
        memRdDataValid = 1'b1;
        memRdData = rd(a);
        memRdErr = (a == errAddr);
      end
    end
  end

  // monitor: compare each accepted response with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      rspReady = 1'b0;
      if (rstN && rspValid) begin
        if (holdCycles > 0) begin
          holdCycles--;
          check(reqReady == 1'b0, "R9 reqReady low while response pending", {31'h0, reqReady}, 32'h0);
        end else if (expStatQ.size() == 0) begin
          check(1'b0, "R9 unexpected response", {30'h0, rspStatus}, 32'h0);
          rspReady = 1'b1;
        end else begin
          logic [1:0]  st;
          logic [31:0] va;
          bit          wr;
          string       tag;
          int          n;
          rspReady = 1'b1;
          st = expStatQ.pop_front();
          va = expVaQ.pop_front();
          wr = expWrQ.pop_front();
          tag = tagQ.pop_front();
          n = expNQ.pop_front();
          check(rspStatus == st, {tag, " status"}, {30'h0, rspStatus}, {30'h0, st});
          check(rspPaddr == expPaddrQ[0], {tag, " R5 R8 paddr"}, rspPaddr, expPaddrQ[0]);
          check(rspFlags == expFlagsQ[0], {tag, " R5 R8 flags"}, {24'h0, rspFlags}, {24'h0, expFlagsQ[0]});
          void'(expPaddrQ.pop_front());
          void'(expFlagsQ.pop_front());
          if (st != 2'd0) begin
            check(faultAddr == va, {tag, " R8 faultAddr"}, faultAddr, va);
            check(faultWrite == wr, {tag, " R8 faultWrite"}, {31'h0, faultWrite}, {31'h0, wr});
          end
          check(gotAddrQ.size() == n, {tag, " R3 R4 read count"}, gotAddrQ.size(), n);
          for (int i = 0; i < n; i++) begin
            logic [31:0] ea;
            ea = expAddrQ.pop_front();
            if (i < gotAddrQ.size())
              check(gotAddrQ[i] == ea, i == 0 ? {tag, " R1 first read address"} : {tag, " R2 second read address"},
                    gotAddrQ[i], ea);
          end
          gotAddrQ.delete();
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // first level at 0x10000
    memArr[32'h0001_0004] = 32'h0002_0001;
    memArr[32'h0002_0014] = 32'hABCD_E0F7;  // present, rd, wr, attributes
    memArr[32'h0002_001C] = 32'h1234_5003;  // read only
    memArr[32'h0002_0020] = 32'h5555_5005;  // write only
    // second table set
    memArr[32'h0003_0004] = 32'h0004_0001;
    memArr[32'h0004_0014] = 32'h0FFF_F1FF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R10 reqReady after reset", {31'h0, reqReady}, 32'h1);
    check(rspValid == 1'b0, "R10 rspValid after reset", {31'h0, rspValid}, 32'h0);
    check(memRdValid == 1'b0, "R10 memRdValid after reset", {31'h0, memRdValid}, 32'h0);
    check(faultAddr == 32'h0, "R10 faultAddr after reset", faultAddr, 32'h0);

    doWalk(32'h0040_5123, 1'b0, "R5 read ok");
    doWalk(32'h0040_5FFF, 1'b1, "R5 write ok");
    doWalk(32'h0080_0456, 1'b0, "R3 first level missing");
    doWalk(32'h0040_6010, 1'b1, "R4 second level missing");
    doWalk(32'h0040_7ABC, 1'b0, "R6 read on read-only");
    doWalk(32'h0040_7ABC, 1'b1, "R6 write on read-only");
    doWalk(32'h0040_8004, 1'b0, "R6 read on write-only");
    doWalk(32'h0040_8004, 1'b1, "R6 write on write-only");
    errAddr = 32'h0001_0004;
    doWalk(32'h0040_5123, 1'b1, "R7 bus error first read");
    errAddr = 32'h0002_0014;
    doWalk(32'h0040_5321, 1'b0, "R7 bus error second read");
    errAddr = 32'hFFFF_FFFF;
    dirBase = 32'h0003_0000;
    holdCycles = 3;
    doWalk(32'h0040_5123, 1'b0, "R1 R9 new base held response");
    dirBase = 32'h0001_0000;
    doWalk(32'h0040_5ABC, 1'b0, "R5 after base restore");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule